// File: doc/BRIEF.md
# Power Domain Shutdown Sequencer

This block runs from the always-on supply and sequences one switchable power domain between its on and off states. A one-cycle request pulse selects power-down or power-up. The block then drives the isolation enable, the retention save strobe, the power switch enable, the domain reset and the retention restore strobe in a fixed order. The power switch, the isolation cells and the retention flops sit outside the block. The switch returns an acknowledge that follows its enable after some delay, and the sequencer waits for that acknowledge in both directions before it moves on.

During power-down, isolation is applied first. The save strobe then fires, and only after that is the switch opened. The domain counts as off once the acknowledge has fallen. During power-up, the switch closes and the block waits for the acknowledge. It then holds the domain in reset for a set number of cycles, fires the restore strobe, and removes isolation last. A request that arrives mid-sequence is held and acted on when the sequence ends. If the acknowledge never arrives, a sticky error is raised and the block freezes in its wait state until reset.

Top module: `pdom_seq`

## Requirements
- R1: After reset the domain is reported on: dom_on=1, sw_en=1, iso_en=0, busy=0, ack_timeout=0, and ret_save, ret_restore and dom_rst are all 0.
- R2: A power-down request (req_valid=1 with req_down=1) accepted while on raises iso_en on the next cycle with sw_en still 1. The cycle after that, ret_save is 1 for exactly one cycle. sw_en falls on the cycle after the save pulse.
- R3: With sw_en low, the block waits for sw_ack=0. It enters the off state (dom_on=0, busy=0, iso_en=1, sw_en=0) on the cycle after sw_ack is sampled low.
- R4: A power-up request (req_valid=1 with req_down=0) accepted while off raises sw_en on the next cycle and holds it while waiting for sw_ack=1, with iso_en still 1.
- R5: On the cycle after sw_ack is sampled high in the power-up wait, dom_rst goes to 1 and stays there for exactly RST_CYC cycles.
- R6: Directly after the reset window, ret_restore is 1 for one cycle with iso_en still 1. On the next cycle iso_en falls and dom_on becomes 1.
- R7: iso_en is 1 whenever sw_en is 0, and from the first cycle of a power-down until the cycle after the restore pulse.
- R8: A request that arrives while busy=1 is held. The latest such request is carried out when the running sequence finishes.
- R9: A request for the state the domain already has (power-down while off, power-up while on) is ignored, and every output stays unchanged.
- R10: If the awaited sw_ack level is not seen within ACK_TMO cycles of entering a wait, ack_timeout rises. It stays high, and every other output stays frozen whatever sw_ack does, until rst_n is asserted.
- R11: busy is 1 exactly when the block is neither in the on nor in the off state. dom_on is 1 only in the on state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_down | input | 1 | Request direction: 1 power-down, 0 power-up |
| sw_ack | input | 1 | Power switch acknowledge (1 = domain powered) |
| iso_en | output | 1 | Isolation enable for the domain outputs |
| ret_save | output | 1 | Retention save strobe |
| sw_en | output | 1 | Power switch enable (1 = supply connected) |
| dom_rst | output | 1 | Domain reset, active high |
| ret_restore | output | 1 | Retention restore strobe |
| busy | output | 1 | A sequence is in progress |
| dom_on | output | 1 | Domain is in the on state |
| ack_timeout | output | 1 | Sticky acknowledge timeout error |

## Verification
The bench builds the block with ACK_TMO=16 and RST_CYC=3. These small values put a full timeout and several complete power cycles within a few hundred clocks. A multi-cycle reset window shows that the exact length of dom_rst is counted correctly. The switch model answers after a programmable delay that the bench varies between runs. It can also be held stuck, so that the same stimulus reaches both a normal acknowledge and a timeout, and shows that a late acknowledge is ignored once the error is set.

// File: rtl/pdom_seq_pkg.sv
// Shared types for the power domain sequencer.
package pdom_seq_pkg;
    // Sequencer states; outputs are decoded from these
    typedef enum logic [3:0] {
        ST_ON    = 4'd0,
        ST_ISO   = 4'd1,
        ST_SAVE  = 4'd2,
        ST_WOFF  = 4'd3,
        ST_OFF   = 4'd4,
        ST_WON   = 4'd5,
        ST_RST   = 4'd6,
        ST_RSTR  = 4'd7
    } seq_st_t;
endpackage

// File: rtl/pdom_req_hold.sv
// Request holding register.
// Remembers the latest request seen while a sequence runs and drops it
// once the sequencer is idle (idle consumes or ignores every request).
// Assumes req_valid is a single-cycle strobe.
module pdom_req_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_down,
    input  logic idle,
    output logic pend_v,
    output logic pend_down
);
    // Capture a request during a sequence, clear it when idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v    <= 1'b0;
            pend_down <= 1'b0;
        end else if (idle) begin
            pend_v    <= 1'b0;
        end else if (req_valid) begin
            pend_v    <= 1'b1;
            pend_down <= req_down;
        end
    end
endmodule

// File: rtl/pdom_step_timer.sv
// Saturating cycle counter for the sequencer.
// Restarts from zero on clr, otherwise counts up and holds at its maximum.
module pdom_step_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] CMAX = '1;

    // Count cycles spent in the current state
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (cnt != CMAX) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pdom_seq_core.sv
// Sequencer state machine.
// Walks the power-down and power-up orders, waits on the switch
// acknowledge, and freezes with a sticky error when it times out.
// Assumes cnt restarts at zero on the cycle a new state is entered.
module pdom_seq_core
    import pdom_seq_pkg::*;
#(
    parameter int ACK_TMO = 16,
    parameter int RST_CYC = 3,
    parameter int CW      = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_v,
    input  logic          req_down,
    input  logic          sw_ack,
    input  logic [CW-1:0] cnt,
    output seq_st_t       st_q,
    output logic          st_chg,
    output logic          err_q
);
    localparam logic [CW-1:0] TMO_LAST = CW'(ACK_TMO - 1);
    localparam logic [CW-1:0] RST_LAST = CW'(RST_CYC - 1);

    seq_st_t st_d;
    logic    err_d;

    // Next-state and timeout decision
    always_comb begin
        st_d  = st_q;
        err_d = err_q;
        case (st_q)
            ST_ON:   if (req_v && req_down) st_d = ST_ISO;
            ST_ISO:  st_d = ST_SAVE;
            ST_SAVE: st_d = ST_WOFF;
            ST_WOFF: if (!err_q) begin
                         if (!sw_ack) st_d = ST_OFF;
                         else if (cnt == TMO_LAST) err_d = 1'b1;
                     end
            ST_OFF:  if (req_v && !req_down) st_d = ST_WON;
            ST_WON:  if (!err_q) begin
                         if (sw_ack) st_d = ST_RST;
                         else if (cnt == TMO_LAST) err_d = 1'b1;
                     end
            ST_RST:  if (cnt == RST_LAST) st_d = ST_RSTR;
            ST_RSTR: st_d = ST_ON;
            default: st_d = ST_ON;
        endcase
    end

    assign st_chg = (st_d != st_q);

    // State and sticky error registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_ON;
            err_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            err_q <= err_d;
        end
    end
endmodule

// File: rtl/pdom_seq.sv
// Power domain shutdown/startup sequencer (top).
// Combines the request holder, the step timer and the state machine,
// and decodes the domain control outputs from the state.
// Assumes sw_ack is synchronous to clk and follows sw_en after a delay.
module pdom_seq
    import pdom_seq_pkg::*;
#(
    parameter int ACK_TMO = 16,
    parameter int RST_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_down,
    input  logic sw_ack,
    output logic iso_en,
    output logic ret_save,
    output logic sw_en,
    output logic dom_rst,
    output logic ret_restore,
    output logic busy,
    output logic dom_on,
    output logic ack_timeout
);
    localparam int CMAXV = (ACK_TMO > RST_CYC) ? ACK_TMO : RST_CYC;
    localparam int CW    = $clog2(CMAXV + 1) + 1;

    seq_st_t       st;
    logic          st_chg, idle, pend_v, pend_down, eff_v, eff_down, err;
    logic [CW-1:0] cnt;

    assign idle     = (st == ST_ON) || (st == ST_OFF);
    assign eff_v    = req_valid || pend_v;
    assign eff_down = req_valid ? req_down : pend_down;

    pdom_req_hold u_hold (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_down(req_down),
        .idle(idle), .pend_v(pend_v), .pend_down(pend_down)
    );

    pdom_step_timer #(.W(CW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .clr(st_chg), .cnt(cnt)
    );

    pdom_seq_core #(.ACK_TMO(ACK_TMO), .RST_CYC(RST_CYC), .CW(CW)) u_core (
        .clk(clk), .rst_n(rst_n), .req_v(eff_v), .req_down(eff_down),
        .sw_ack(sw_ack), .cnt(cnt), .st_q(st), .st_chg(st_chg), .err_q(err)
    );

    // Output decode from the current state
    always_comb begin
        iso_en      = (st != ST_ON);
        sw_en       = !((st == ST_WOFF) || (st == ST_OFF));
        ret_save    = (st == ST_SAVE);
        dom_rst     = (st == ST_RST);
        ret_restore = (st == ST_RSTR);
        busy        = !idle;
        dom_on      = (st == ST_ON);
        ack_timeout = err;
    end
endmodule

// File: rtl/pdom_seq_chk.sv
// Property checker for the power domain sequencer, attached by bind.
module pdom_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic sw_ack,
    input logic iso_en,
    input logic ret_save,
    input logic sw_en,
    input logic dom_rst,
    input logic ret_restore,
    input logic busy,
    input logic dom_on,
    input logic ack_timeout
);
    assert_save_isolated_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ret_save |-> (iso_en && sw_en));
    assert_save_then_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ret_save |=> !sw_en);
    assert_ack_before_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dom_rst) |-> $past(sw_ack));
    assert_restore_after_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ret_restore |-> ($past(dom_rst) && iso_en));
    assert_iso_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(iso_en) |-> $past(ret_restore));
    assert_off_isolated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_en |-> iso_en);
    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ack_timeout |=> ack_timeout);
    assert_err_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ack_timeout |=> $stable({iso_en, sw_en, dom_rst, busy, dom_on}));
    assert_status_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && dom_on));
    assert_strobes_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ret_save, ret_restore, dom_rst}));
endmodule

bind pdom_seq pdom_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sw_ack(sw_ack), .iso_en(iso_en),
    .ret_save(ret_save), .sw_en(sw_en), .dom_rst(dom_rst),
    .ret_restore(ret_restore), .busy(busy), .dom_on(dom_on),
    .ack_timeout(ack_timeout)
);

// File: tb/tb_pdom_seq.sv
// Bench: behavioural reference model compared every cycle, plus directed checks.
module tb_pdom_seq;
    localparam int TMO = 16;
    localparam int RSTC = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_down = 1'b0;
    logic sw_ack = 1'b1;
    logic iso_en, ret_save, sw_en, dom_rst, ret_restore, busy, dom_on, ack_timeout;

    int checks = 0;
    int fails = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    pdom_seq #(.ACK_TMO(TMO), .RST_CYC(RSTC)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_down(req_down),
        .sw_ack(sw_ack), .iso_en(iso_en), .ret_save(ret_save), .sw_en(sw_en),
        .dom_rst(dom_rst), .ret_restore(ret_restore), .busy(busy),
        .dom_on(dom_on), .ack_timeout(ack_timeout)
    );

    task automatic chk(input string rq, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", rq, what, act, exp, cycles);
        end
    endtask

    // Switch model: ack follows sw_en after ack_dly negedges unless stuck
    int  ack_dly = 3;
    bit  stuck = 0;
    bit  last_sw = 1;
    int  ack_cnt = 0;
    always @(negedge clk) begin
        if (sw_en !== last_sw) begin
            last_sw = sw_en;
            ack_cnt = 0;
        end else if (ack_cnt < ack_dly) ack_cnt++;
        if (ack_cnt >= ack_dly && !stuck) sw_ack = last_sw;
    end

    // Reference model: phase 0 on,1 iso,2 save,3 wait-off,4 off,5 wait-on,6 reset,7 restore
    int m_ph = 0, m_nph = 0, m_cnt = 0;
    bit m_err = 0, m_pv = 0, m_pd = 0, m_live = 0, m_ev, m_ed;
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_err = 0; m_pv = 0; m_pd = 0; m_live = 1;
        end else begin
            m_ev = req_valid || m_pv;
            m_ed = req_valid ? req_down : m_pd;
            m_nph = m_ph;
            if (m_ph == 0 && m_ev && m_ed) m_nph = 1;
            else if (m_ph == 1) m_nph = 2;
            else if (m_ph == 2) m_nph = 3;
            else if (m_ph == 3 && !m_err) begin
                if (!sw_ack) m_nph = 4; else if (m_cnt == TMO - 1) m_err = 1;
            end else if (m_ph == 4 && m_ev && !m_ed) m_nph = 5;
            else if (m_ph == 5 && !m_err) begin
                if (sw_ack) m_nph = 6; else if (m_cnt == TMO - 1) m_err = 1;
            end else if (m_ph == 6 && m_cnt == RSTC - 1) m_nph = 7;
            else if (m_ph == 7) m_nph = 0;
            if (m_ph == 0 || m_ph == 4) m_pv = 0;
            else if (req_valid) begin m_pv = 1; m_pd = req_down; end
            m_cnt = (m_nph != m_ph) ? 0 : m_cnt + 1;
            m_ph = m_nph;
        end
    end

    // Compare every output with the model away from the active edge
    always @(negedge clk) begin
        if (m_live) begin
            chk("R7", "iso_en", int'(iso_en), int'(m_ph != 0));
            chk("R2", "ret_save", int'(ret_save), int'(m_ph == 2));
            chk("R4", "sw_en", int'(sw_en), int'(m_ph != 3 && m_ph != 4));
            chk("R5", "dom_rst", int'(dom_rst), int'(m_ph == 6));
            chk("R6", "ret_restore", int'(ret_restore), int'(m_ph == 7));
            chk("R11", "busy", int'(busy), int'(m_ph != 0 && m_ph != 4));
            chk("R11", "dom_on", int'(dom_on), int'(m_ph == 0));
            chk("R10", "ack_timeout", int'(ack_timeout), int'(m_err));
        end
    end

    task automatic send(input bit down);
        @(negedge clk);
        req_valid = 1'b1;
        req_down  = down;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200; i++) begin
            if (!busy) break;
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "dom_on", int'(dom_on), 1);
        chk("R1", "iso_en", int'(iso_en), 0);
        chk("R1", "sw_en", int'(sw_en), 1);
        chk("R1", "busy|err|strobes", int'(busy | ack_timeout | ret_save | ret_restore | dom_rst), 0);
        rst_n = 1'b1;
    endtask

    int rst_len;

    initial begin
        do_reset();
        // R9: power-up while on is ignored
        send(1'b0);
        chk("R9", "busy after up-while-on", int'(busy), 0);
        repeat (2) @(negedge clk);
        chk("R9", "dom_on after up-while-on", int'(dom_on), 1);
        // R2/R3: power-down with delay 4
        ack_dly = 4;
        send(1'b1);
        chk("R2", "iso raised, switch still on", int'(iso_en & sw_en), 1);
        @(negedge clk);
        chk("R2", "save strobe", int'(ret_save), 1);
        @(negedge clk);
        chk("R2", "switch opened after save", int'(sw_en | ret_save), 0);
        wait_idle();
        chk("R3", "off state", int'({dom_on, iso_en, sw_en}), 3'b010);
        // R9: power-down while off is ignored
        send(1'b1);
        repeat (2) @(negedge clk);
        chk("R9", "still off, idle", int'({busy, dom_on, sw_en}), 0);
        // R4/R5/R6: power-up with delay 5, R8: down requested mid-sequence
        ack_dly = 5;
        send(1'b0);
        chk("R4", "switch closed, isolated", int'(sw_en & iso_en), 1);
        @(negedge clk);
        send(1'b1);
        while (!dom_rst && cycles < 5000) @(negedge clk);
        rst_len = 0;
        while (dom_rst && cycles < 5000) begin rst_len++; @(negedge clk); end
        chk("R5", "reset window length", rst_len, RSTC);
        chk("R6", "restore after reset, isolated", int'(ret_restore & iso_en), 1);
        @(negedge clk);
        chk("R6", "on with isolation removed", int'({dom_on, iso_en}), 2'b10);
        @(negedge clk);
        chk("R8", "held down request starts", int'(busy & iso_en), 1);
        wait_idle();
        chk("R8", "off after held request", int'(dom_on), 0);
        // R10: acknowledge stuck low during power-up
        ack_dly = 2;
        stuck = 1;
        send(1'b0);
        repeat (TMO + 2) @(negedge clk);
        chk("R10", "timeout raised", int'(ack_timeout), 1);
        stuck = 0;
        repeat (8) @(negedge clk);
        chk("R10", "late ack ignored", int'({ack_timeout, busy, dom_rst, sw_en}), 4'b1101);
        do_reset();
        chk("R10", "error cleared by reset", int'(ack_timeout), 0);
        // Second round trip with a short delay
        ack_dly = 1;
        send(1'b1);
        wait_idle();
        chk("R3", "off with short delay", int'(dom_on), 0);
        send(1'b0);
        wait_idle();
        chk("R6", "on with short delay", int'({dom_on, iso_en}), 2'b10);
        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        #100000;
        checks++;
        fails++;
        $display("FAIL watchdog expired at cycle %0d", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule